// File: doc/BRIEF.md
# Addressed serial command decoder for a quad digital potentiometer

This block sits between a four-wire serial host link and the register bank of a quad digital potentiometer controller. The serial clock, data-in, active-low chip select and active-low pause inputs all arrive asynchronously. Each one passes through a two-flop synchroniser, and every edge is detected in the system clock domain. Data is taken on rising serial-clock edges and read data is changed on falling ones.

A frame starts with a falling chip select. Its first byte carries a fixed device-type nibble, two zero bits and a two-bit strap address. If that byte does not match, the rest of the frame is discarded. The second byte holds an opcode nibble, a data-register select and a pot select.

The opcode decides what follows. Transfer commands end after the second byte. Read and write commands carry a third byte of six data bits. The step command is open-ended: every further clock pulse moves the selected wiper one position, up or down according to the level of the data line. The bank sees a single-cycle command strobe together with held opcode, selects and write data, and it sees a separate step pulse stream. The bank returns read data, which the block shifts out MSB first on a serial output with an output-enable.

Top module: `spi_pot_cmd_decoder`

## Requirements
- R1: After reset, cmd_stb_o, step_o and so_oe_o are 0.
- R2: The first byte of a frame is accepted only when it equals {4'b0101, 2'b00, strap_i[1:0]}, MSB first. On a mismatch the rest of the frame raises no strobe, no step and no serial output.
- R3: The second byte is opcode[7:4], register select[3:2] and pot select[1:0]. For the transfer opcodes 1101, 1110, 0001 and 1000, cmd_stb_o pulses for one cycle once that byte completes, with cmd_op_o, reg_sel_o and pot_sel_o holding those fields.
- R4: For the write opcodes 1010 and 1100, no strobe is given after the second byte. Once a third byte of the form 00 followed by D5..D0 completes, cmd_stb_o pulses with wr_data_o = D5..D0. A third byte whose top two bits are not 00 gives no strobe.
- R5: For the read opcodes 1001, 1011 and 0101, cmd_stb_o pulses once the second byte completes. During the third byte so_oe_o is 1 and so_o presents {2'b00, rd_data_i} MSB first, each bit changing on a falling serial-clock edge.
- R6: After opcode 0010, every later rising serial-clock edge gives a one-cycle step_o pulse, with step_up_o equal to the data-line level at that edge (1 = up). Pulses stop once chip select rises. This opcode never raises cmd_stb_o.
- R7: A fall of holdn_i while the serial clock is low pauses the frame. While paused, clock edges are ignored and so_oe_o is 0. A rise of holdn_i while the serial clock is low resumes the frame where it stopped.
- R8: After reset, nothing is decoded until a high-to-low transition of csn_i has been seen.
- R9: A rise of chip select before a frame is complete cancels it with no strobe, and the next frame decodes normally.
- R10: Opcodes outside the ten listed above give no strobe and no step pulses.
- R11: so_oe_o is 0 whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock, asynchronous |
| si_i | input | 1 | Serial data in |
| csn_i | input | 1 | Chip select, active low |
| holdn_i | input | 1 | Frame pause, active low |
| strap_i | input | 2 | Strap address compared with the first byte |
| rd_data_i | input | 6 | Read-back value from the register bank |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o (0 = high impedance) |
| cmd_stb_o | output | 1 | One-cycle command strobe |
| cmd_op_o | output | 4 | Opcode of the current frame |
| pot_sel_o | output | 2 | Pot select |
| reg_sel_o | output | 2 | Data-register select |
| wr_data_o | output | 6 | Write data of the last write command |
| step_o | output | 1 | One-cycle wiper step pulse |
| step_up_o | output | 1 | Direction of the last step (1 = toward high end) |

## Verification
The assertions check on every cycle that strobes and step pulses last one cycle and never coincide. They also check that a strobe only ever carries a recognised non-step opcode, that nothing fires before the first chip-select fall, and that the output driver is off while chip select stays high. Only the directed scenarios can show the rest. These are the field decoding, the serial read-back value and its bit order, the rejection of each kind of bad identification byte, step counts and directions, pause-and-resume keeping the frame intact, and cancellation by an early chip-select rise.

// File: rtl/pcd_pkg.sv
// Shared types and opcode classification for the serial command decoder.
// Assumes a fixed 4-bit opcode field; the class drives the frame sequencing.
package pcd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ID,
        ST_INSTR,
        ST_DATA,
        ST_STEP,
        ST_SKIP
    } pcd_state_t;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_XFER,
        CL_READ,
        CL_WRITE,
        CL_STEP
    } pcd_class_t;

    localparam logic [3:0] OP_RD_WIPER  = 4'b1001;
    localparam logic [3:0] OP_WR_WIPER  = 4'b1010;
    localparam logic [3:0] OP_RD_DREG   = 4'b1011;
    localparam logic [3:0] OP_WR_DREG   = 4'b1100;
    localparam logic [3:0] OP_DREG2WIP  = 4'b1101;
    localparam logic [3:0] OP_WIP2DREG  = 4'b1110;
    localparam logic [3:0] OP_ALL_D2W   = 4'b0001;
    localparam logic [3:0] OP_ALL_W2D   = 4'b1000;
    localparam logic [3:0] OP_STEP      = 4'b0010;
    localparam logic [3:0] OP_STATUS    = 4'b0101;

    // Map an opcode onto the frame shape it needs.
    function automatic pcd_class_t classify(input logic [3:0] op);
        pcd_class_t c;
        case (op)
            OP_DREG2WIP, OP_WIP2DREG, OP_ALL_D2W, OP_ALL_W2D: c = CL_XFER;
            OP_RD_WIPER, OP_RD_DREG, OP_STATUS:               c = CL_READ;
            OP_WR_WIPER, OP_WR_DREG:                          c = CL_WRITE;
            OP_STEP:                                          c = CL_STEP;
            default:                                          c = CL_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pcd_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes each bit is an independent slow level; reset value is per bit.
module pcd_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage captures the raw inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= d_i;
                end
            end else begin : g_next
                // Later stages resolve metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pcd_edge.sv
// Rise/fall detector for synchronised levels.
// Assumes the reset value equals the synchroniser's, so no edge follows reset.
module pcd_edge #(
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    logic [WIDTH-1:0] prev_q;

    // Remember the previous level of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= d_i;
    end

    assign rise_o = d_i & ~prev_q;
    assign fall_o = ~d_i & prev_q;

endmodule

// File: rtl/pcd_rx.sv
// Serial-to-parallel byte assembler with bit counter, MSB first.
// Assumes en is a one-cycle pulse per sampled bit; done_o pulses the cycle after the last bit.
module pcd_rx #(
    parameter  int BYTE_W = 8,
    localparam int CNT_W  = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic              bit_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  cnt_o
);

    logic [BYTE_W-2:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] byte_q;
    logic              done_q;

    // Shift bits in and publish each complete byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            byte_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (clr_i) begin
                sh_q  <= '0;
                cnt_q <= '0;
            end else if (en_i) begin
                if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                    byte_q <= {sh_q, bit_i};
                    done_q <= 1'b1;
                    cnt_q  <= '0;
                end else begin
                    sh_q  <= {sh_q[BYTE_W-3:0], bit_i};
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign byte_o = byte_q;
    assign done_o = done_q;
    assign cnt_o  = cnt_q;

endmodule

// File: rtl/pcd_tx.sv
// Parallel-to-serial shifter for read-back bytes, MSB first, zero padded on top.
// Assumes load and shift are never both set.
module pcd_tx #(
    parameter int BYTE_W = 8,
    parameter int DATA_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              bit_o
);

    localparam int PAD_W = BYTE_W - DATA_W;

    logic [BYTE_W-1:0] sh_q;

    // Load the padded read value or move the next bit to the top.
    always_ff @(posedge clk) begin
        if (!rst_n)       sh_q <= '0;
        else if (clr_i)   sh_q <= '0;
        else if (load_i)  sh_q <= {{PAD_W{1'b0}}, data_i};
        else if (shift_i) sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
    end

    assign bit_o = sh_q[BYTE_W-1];

endmodule

// File: rtl/spi_pot_cmd_decoder.sv
// Frame decoder for a quad potentiometer serial link. It synchronises the serial
// pins, checks the identification byte, decodes the instruction, gathers write
// data, serialises read data, and turns the open-ended step command into pulses.
// Assumes the serial clock half period spans several system clocks and the strap
// pins are static.
module spi_pot_cmd_decoder #(
    parameter int         DATA_W      = 6,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_TYPE    = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              si_i,
    input  logic              csn_i,
    input  logic              holdn_i,
    input  logic [1:0]        strap_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic              cmd_stb_o,
    output logic [3:0]        cmd_op_o,
    output logic [1:0]        pot_sel_o,
    output logic [1:0]        reg_sel_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              step_o,
    output logic              step_up_o
);
    import pcd_pkg::*;

    localparam int BYTE_W  = 8;
    localparam int CNT_W   = $clog2(BYTE_W);
    localparam int ID_PAD  = BYTE_W - 4 - 2;
    localparam int WD_PAD  = BYTE_W - DATA_W;

    // Synchronised pins, packed as {hold, cs, si, sck}; cs resets low so that
    // only a real fall after reset opens a frame.
    logic [3:0] pins_s;
    logic       sck_s, si_s, csn_s, holdn_s;

    pcd_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({holdn_i, csn_i, si_i, sck_i}),
        .q_o   (pins_s)
    );
    assign {holdn_s, csn_s, si_s, sck_s} = pins_s;

    logic [2:0] rise, fall;
    logic       sck_r, sck_f, csn_r, csn_f, hold_r, hold_f;

    pcd_edge #(.WIDTH(3), .RST_VAL(3'b100)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    ({holdn_s, csn_s, sck_s}),
        .rise_o (rise),
        .fall_o (fall)
    );
    assign {hold_r, csn_r, sck_r} = rise;
    assign {hold_f, csn_f, sck_f} = fall;

    pcd_state_t        state_q;
    logic              paused_q;
    logic              rd_mode_q;
    logic [3:0]        op_q;
    logic [1:0]        pot_q, reg_q;
    logic [DATA_W-1:0] wd_q;
    logic              stb_q, step_q, up_q;

    logic              live_rise, live_fall;
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_done;
    logic [CNT_W-1:0]  rx_cnt;
    logic              tx_bit, tx_load, tx_shift, reading;
    logic [BYTE_W-1:0] id_expect;
    pcd_class_t        op_class;

    assign live_rise = sck_r & ~paused_q & (state_q != ST_IDLE);
    assign live_fall = sck_f & ~paused_q & (state_q != ST_IDLE);
    assign reading   = (state_q == ST_DATA) & rd_mode_q;
    assign id_expect = {DEV_TYPE, {ID_PAD{1'b0}}, strap_i};
    assign op_class  = classify(rx_byte[7:4]);

    pcd_rx #(.BYTE_W(BYTE_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (csn_f),
        .en_i   (live_rise),
        .bit_i  (si_s),
        .byte_o (rx_byte),
        .done_o (rx_done),
        .cnt_o  (rx_cnt)
    );

    assign tx_load  = live_fall & reading & (rx_cnt == '0);
    assign tx_shift = live_fall & reading & (rx_cnt != '0);

    pcd_tx #(.BYTE_W(BYTE_W), .DATA_W(DATA_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (csn_f),
        .load_i  (tx_load),
        .shift_i (tx_shift),
        .data_i  (rd_data_i),
        .bit_o   (tx_bit)
    );

    // Pause flag: set and cleared only by pause edges seen while the clock is low.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     paused_q <= 1'b0;
        else if (csn_f || csn_r)                        paused_q <= 1'b0;
        else if (hold_f && !sck_s && state_q != ST_IDLE) paused_q <= 1'b1;
        else if (hold_r && !sck_s)                      paused_q <= 1'b0;
    end

    // Frame sequencer: identification, instruction, data, or step phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rd_mode_q <= 1'b0;
            op_q      <= '0;
            pot_q     <= '0;
            reg_q     <= '0;
            wd_q      <= '0;
            stb_q     <= 1'b0;
            step_q    <= 1'b0;
            up_q      <= 1'b0;
        end else begin
            stb_q  <= 1'b0;
            step_q <= 1'b0;
            if (csn_r) begin
                state_q <= ST_IDLE;
            end else if (csn_f) begin
                state_q   <= ST_ID;
                rd_mode_q <= 1'b0;
            end else begin
                case (state_q)
                    ST_ID: if (rx_done) begin
                        state_q <= (rx_byte == id_expect) ? ST_INSTR : ST_SKIP;
                    end
                    ST_INSTR: if (rx_done) begin
                        op_q  <= rx_byte[7:4];
                        reg_q <= rx_byte[3:2];
                        pot_q <= rx_byte[1:0];
                        case (op_class)
                            CL_XFER: begin
                                stb_q   <= 1'b1;
                                state_q <= ST_SKIP;
                            end
                            CL_READ: begin
                                stb_q     <= 1'b1;
                                rd_mode_q <= 1'b1;
                                state_q   <= ST_DATA;
                            end
                            CL_WRITE: state_q <= ST_DATA;
                            CL_STEP:  state_q <= ST_STEP;
                            default:  state_q <= ST_SKIP;
                        endcase
                    end
                    ST_DATA: if (rx_done) begin
                        if (!rd_mode_q && rx_byte[BYTE_W-1 -: WD_PAD] == '0) begin
                            wd_q  <= rx_byte[DATA_W-1:0];
                            stb_q <= 1'b1;
                        end
                        state_q <= ST_SKIP;
                    end
                    ST_STEP: if (live_rise) begin
                        step_q <= 1'b1;
                        up_q   <= si_s;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign so_o      = tx_bit;
    assign so_oe_o   = reading & ~paused_q;
    assign cmd_stb_o = stb_q;
    assign cmd_op_o  = op_q;
    assign pot_sel_o = pot_q;
    assign reg_sel_o = reg_q;
    assign wr_data_o = wd_q;
    assign step_o    = step_q;
    assign step_up_o = up_q;

endmodule

// File: rtl/pcd_checker.sv
// Property checker for the serial command decoder, bound to the top module.
// Assumes the top's port names; watches ports only.
module pcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       csn_i,
    input logic       so_oe_o,
    input logic       cmd_stb_o,
    input logic [3:0] cmd_op_o,
    input logic       step_o
);

    logic       csn_prev_q;
    logic       seen_fall_q;
    logic [2:0] hi_cnt_q;

    // Track the raw chip select: first fall since reset and length of high run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csn_prev_q  <= 1'b0;
            seen_fall_q <= 1'b0;
            hi_cnt_q    <= '0;
        end else begin
            csn_prev_q <= csn_i;
            if (csn_prev_q && !csn_i) seen_fall_q <= 1'b1;
            if (!csn_i)                  hi_cnt_q <= '0;
            else if (hi_cnt_q != 3'd7)   hi_cnt_q <= hi_cnt_q + 1'b1;
        end
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb_o |=> !cmd_stb_o); // R3

    AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !step_o); // R6

    AST_STB_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_stb_o, step_o})); // R6

    AST_STB_KNOWN_OP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb_o |-> (cmd_op_o == 4'b1001 || cmd_op_o == 4'b1010 ||
                       cmd_op_o == 4'b1011 || cmd_op_o == 4'b1100 ||
                       cmd_op_o == 4'b1101 || cmd_op_o == 4'b1110 ||
                       cmd_op_o == 4'b0001 || cmd_op_o == 4'b1000 ||
                       cmd_op_o == 4'b0101)); // R10

    AST_QUIET_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_fall_q |-> (!cmd_stb_o && !step_o && !so_oe_o)); // R8

    AST_OE_OFF_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt_q >= 3'd5) |-> !so_oe_o); // R11

endmodule

bind spi_pot_cmd_decoder pcd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csn_i     (csn_i),
    .so_oe_o   (so_oe_o),
    .cmd_stb_o (cmd_stb_o),
    .cmd_op_o  (cmd_op_o),
    .step_o    (step_o)
);

// File: tb/sim_spi_pot_cmd_decoder.sv
// Directed bench for the serial command decoder: one task per scenario.
module sim_spi_pot_cmd_decoder;

    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, si = 1'b0, csn = 1'b0, holdn = 1'b1;
    logic [1:0] strap = 2'b01;
    logic [5:0] rd_val = '0;
    logic       so, so_oe, stb, step, step_up;
    logic [3:0] op;
    logic [1:0] pot, rsel;
    logic [5:0] wd;

    int checks = 0, failures = 0;
    int stb_cnt = 0, step_cnt = 0, up_cnt = 0;
    logic [7:0] acc;
    bit   oe_bad;
    bit   finished = 1'b0;
    int   cycles = 0;

    always #5 clk = ~clk;

    spi_pot_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .si_i(si), .csn_i(csn),
        .holdn_i(holdn), .strap_i(strap), .rd_data_i(rd_val),
        .so_o(so), .so_oe_o(so_oe), .cmd_stb_o(stb), .cmd_op_o(op),
        .pot_sel_o(pot), .reg_sel_o(rsel), .wr_data_o(wd),
        .step_o(step), .step_up_o(step_up)
    );

    // Count strobes and steps away from the active edge.
    always @(negedge clk) begin
        if (stb)  stb_cnt++;
        if (step) begin step_cnt++; if (step_up) up_cnt++; end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        si = b; tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic read_bits(input int n);
        for (int i = 0; i < n; i++) begin
            si = 1'b0; tick(HALF);
            acc = {acc[6:0], so};
            if (!so_oe) oe_bad = 1'b1;
            sck = 1'b1; tick(HALF); sck = 1'b0;
        end
    endtask

    task automatic cs_lo();
        csn = 1'b0; tick(HALF);
    endtask

    task automatic cs_hi();
        tick(HALF); csn = 1'b1; tick(2 * HALF);
    endtask

    function automatic logic [7:0] id_of(input logic [1:0] a);
        return {4'b0101, 2'b00, a};
    endfunction

    task automatic t_reset_unarmed();
        tick(3);
        check(!stb && !step && !so_oe, "R1 reset outputs", {stb, step, so_oe}, 0);
        send_byte(id_of(strap)); send_byte(8'hD5);
        tick(4);
        check(stb_cnt == 0, "R8 no decode before cs fall", stb_cnt, 0);
        csn = 1'b1; tick(2 * HALF);
    endtask

    task automatic t_transfer();
        int s0 = stb_cnt;
        cs_lo(); send_byte(id_of(strap)); send_byte(8'b1101_10_01); cs_hi();
        check(stb_cnt == s0 + 1, "R3 transfer strobe count", stb_cnt - s0, 1);
        check(op == 4'hD && rsel == 2'd2 && pot == 2'd1, "R3 transfer fields",
              {op, rsel, pot}, {4'hD, 2'd2, 2'd1});
        cs_lo(); send_byte(id_of(strap)); send_byte(8'b1000_11_00); cs_hi();
        check(stb_cnt == s0 + 2 && op == 4'h8 && rsel == 2'd3, "R3 global transfer",
              {op, rsel}, {4'h8, 2'd3});
        check(!so_oe, "R11 oe off with cs high", so_oe, 0);
    endtask

    task automatic t_write();
        int s0 = stb_cnt;
        cs_lo(); send_byte(id_of(strap)); send_byte(8'b1010_00_11); tick(4);
        check(stb_cnt == s0, "R4 no strobe before data byte", stb_cnt - s0, 0);
        send_byte(8'h2A); cs_hi();
        check(stb_cnt == s0 + 1 && wd == 6'h2A && op == 4'hA && pot == 2'd3,
              "R4 write data", wd, 6'h2A);
        cs_lo(); send_byte(id_of(strap)); send_byte(8'b1100_01_00); send_byte(8'hC5); cs_hi();
        check(stb_cnt == s0 + 1, "R4 bad pad bits ignored", stb_cnt - s0, 1);
    endtask

    task automatic t_read();
        int s0 = stb_cnt;
        rd_val = 6'h35; oe_bad = 1'b0;
        cs_lo(); send_byte(id_of(strap)); send_byte(8'b1011_10_10);
        check(stb_cnt == s0 + 1 && op == 4'hB, "R5 read strobe", stb_cnt - s0, 1);
        read_bits(8); cs_hi();
        check(acc == 8'h35, "R5 read data", acc, 8'h35);
        check(!oe_bad, "R5 oe during read byte", oe_bad, 0);
        check(!so_oe, "R11 oe off after read", so_oe, 0);
        rd_val = 6'h01;
        cs_lo(); send_byte(id_of(strap)); send_byte(8'b0101_00_00); read_bits(8); cs_hi();
        check(acc == 8'h01 && op == 4'h5, "R5 status read", acc, 8'h01);
    endtask

    task automatic t_bad_id();
        int s0 = stb_cnt;
        logic [7:0] bad [4] = '{8'h52, 8'h71, 8'h61, 8'h55};
        foreach (bad[k]) begin
            cs_lo(); send_byte(bad[k]); send_byte(8'hD0); cs_hi();
        end
        check(stb_cnt == s0, "R2 bad id no strobe", stb_cnt - s0, 0);
        oe_bad = 1'b0; rd_val = 6'h3F;
        cs_lo(); send_byte(8'h53); send_byte(8'h90); si = 1'b0; tick(HALF);
        check(!so_oe, "R2 bad id no serial output", so_oe, 0);
        send_byte(8'h00); cs_hi();
        check(stb_cnt == s0, "R2 bad id read ignored", stb_cnt - s0, 0);
        strap = 2'b10;
        cs_lo(); send_byte(8'h52); send_byte(8'hD0); cs_hi();
        check(stb_cnt == s0 + 1, "R2 other strap accepted", stb_cnt - s0, 1);
        strap = 2'b01;
    endtask

    task automatic t_step();
        int s0 = stb_cnt, p0 = step_cnt, u0c = up_cnt;
        cs_lo(); send_byte(id_of(strap)); send_byte(8'b0010_00_10);
        send_bit(1); send_bit(1); send_bit(0); send_bit(1); send_bit(0);
        cs_hi();
        check(step_cnt - p0 == 5, "R6 step count", step_cnt - p0, 5);
        check(up_cnt - u0c == 3, "R6 up steps", up_cnt - u0c, 3);
        check(stb_cnt == s0 && pot == 2'd2, "R6 no strobe, pot held", stb_cnt - s0, 0);
        send_bit(1); send_bit(1); tick(4);
        check(step_cnt - p0 == 5, "R6 no steps after cs rise", step_cnt - p0, 5);
    endtask

    task automatic t_hold();
        int s0 = stb_cnt;
        cs_lo(); send_byte(id_of(strap));
        send_bit(1); send_bit(1); send_bit(1);
        holdn = 1'b0; tick(HALF);
        send_bit(0); send_bit(1); send_bit(0);
        holdn = 1'b1; tick(HALF);
        send_bit(0); send_bit(0); send_bit(1); send_bit(1); send_bit(0);
        cs_hi();
        check(stb_cnt == s0 + 1 && op == 4'hE && rsel == 2'd1 && pot == 2'd2,
              "R7 paused frame resumes", {op, rsel, pot}, {4'hE, 2'd1, 2'd2});
        rd_val = 6'h2D; oe_bad = 1'b0;
        cs_lo(); send_byte(id_of(strap)); send_byte(8'b1001_00_01);
        read_bits(2);
        holdn = 1'b0; tick(2 * HALF);
        check(!so_oe, "R7 oe off while paused", so_oe, 0);
        sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
        holdn = 1'b1; tick(HALF);
        read_bits(6); cs_hi();
        check(acc == 8'h2D && !oe_bad, "R7 read across pause", acc, 8'h2D);
    endtask

    task automatic t_abort();
        int s0 = stb_cnt;
        cs_lo(); send_byte(id_of(strap)); send_bit(1); send_bit(1); send_bit(0); send_bit(1); cs_hi();
        cs_lo(); send_byte(id_of(strap)); send_byte(8'hA0); send_bit(0); send_bit(0); send_bit(1); cs_hi();
        check(stb_cnt == s0, "R9 aborted frames no strobe", stb_cnt - s0, 0);
        cs_lo(); send_byte(id_of(strap)); send_byte(8'b0001_01_00); cs_hi();
        check(stb_cnt == s0 + 1 && op == 4'h1 && rsel == 2'd1, "R9 next frame decodes",
              op, 4'h1);
    endtask

    task automatic t_unknown();
        int s0 = stb_cnt, p0 = step_cnt;
        logic [7:0] ops [3] = '{8'h30, 8'hF5, 8'h0A};
        foreach (ops[k]) begin
            cs_lo(); send_byte(id_of(strap)); send_byte(ops[k]);
            send_bit(1); send_bit(1); cs_hi();
        end
        check(stb_cnt == s0, "R10 unknown opcode no strobe", stb_cnt - s0, 0);
        check(step_cnt == p0, "R10 unknown opcode no step", step_cnt - p0, 0);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        t_reset_unarmed();
        t_transfer();
        t_write();
        t_read();
        t_bad_id();
        t_step();
        t_hold();
        t_abort();
        t_unknown();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule